// File: doc/BRIEF.md
# Decimal Address Modifier Control

This block decides how a five-digit decimal storage address changes while a channel moves characters one at a time. Two request strobes pick the modification: one asks for modify-by-zero (the address is used again unchanged), the other asks for modify-by-plus-one (the address advances). A third input releases the control latches. A modification strobe then applies the selected modification to the held address. Each digit is held in a two-out-of-five code.

The two control latches are built as one registered state machine with three states. MS_IDLE means no modifier is held. MS_ZERO means the modify-by-zero latch is set. MS_PLUS1 means the modify-by-plus-one latch is set. Every conflict between set and release requests has a fixed priority. The transitions are as follows. IDLE_TO_PLUS1 is taken on a plus-one request, whatever the zero request does. IDLE_TO_ZERO is taken on a zero request alone. ZERO_TO_IDLE is taken on a release without a zero request or a plus-one request. ZERO_TO_PLUS1 is taken on a release together with a plus-one request and no zero request. PLUS1_TO_ZERO is taken on a zero request without a plus-one request. PLUS1_TO_IDLE is taken on a release with no request. In every other case the state holds. Because the decision is taken once per clock, the latches cannot oscillate.

The block raises a sticky digit check when it is asked to modify an address that holds an illegal digit code. It raises a sticky address check when an increment passes the top of storage, unless the to-end-of-storage mode is active.

Top module: `amc_addr_modifier`

## Requirements
- R1: While rst_n is low, mod_zero, mod_plus1, digit_check and addr_check are 0 and addr_out is 00000. A latch_reset pulse with no request returns the latches to the idle state on the next clock.
- R2: When set_plus1_req is high and the zero latch is not held, mod_plus1 is 1 and mod_zero is 0 one clock later, even if set_zero_req is high in the same cycle. A set_zero_req without set_plus1_req moves a held plus-one latch to the zero latch.
- R3: While set_zero_req is high, latch_reset does not clear a set zero latch. If both inputs are held, mod_zero stays 1 and mod_plus1 stays 0 on every clock.
- R4: While the zero latch is set and not released, set_plus1_req cannot set mod_plus1, and a mod_strobe leaves addr_out unchanged. A latch_reset together with set_plus1_req, and no set_zero_req, moves the latches to plus-one.
- R5: A mod_strobe while mod_plus1 is 1 replaces addr_out with the decimal address plus one on the next clock, with the carry rippling through all five digits.
- R6: Digit codes are 5 bits, digit i in bits [5i+4:5i], with bit weights 7,4,2,1,0 from bit 4 down to bit 0. Exactly two bits are set, and zero is 11000. Any other pattern is illegal. A mod_strobe on an address with an illegal digit sets digit_check and leaves addr_out unchanged.
- R7: An increment of an address at or above 39999 gives 00000. It sets addr_check unless to_end_mode is high during the strobe.
- R8: digit_check and addr_check stay set until rst_n goes low.
- R9: load_en copies load_addr into addr_out on the next clock and takes priority over mod_strobe.
- R10: A mod_strobe with no latch set leaves addr_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_zero_req | input | 1 | Request to set the modify-by-zero latch |
| set_plus1_req | input | 1 | Request to set the modify-by-plus-one latch |
| latch_reset | input | 1 | Release of the modifier control latches |
| load_en | input | 1 | Load load_addr into the address register |
| load_addr | input | 25 | Address to load, five 2-of-5 digits |
| mod_strobe | input | 1 | Apply the selected modification |
| to_end_mode | input | 1 | Transfer runs to end of storage; suppresses the top check |
| addr_out | output | 25 | Current address, five 2-of-5 digits |
| mod_zero | output | 1 | Modify-by-zero latch |
| mod_plus1 | output | 1 | Modify-by-plus-one latch |
| digit_check | output | 1 | Sticky illegal-digit flag |
| addr_check | output | 1 | Sticky increment-past-top flag |

## Verification
The bench builds the block with its default parameters: five digits and a top address of 39999. Because an address can be loaded directly, the wrap at the top of storage, the carry across all digits and the check suppression in end mode are reached in a few cycles and need no long count. The default width also allows an illegal code to be placed in any single digit, so the digit check is exercised through the normal load path.

// File: rtl/amc_pkg.sv
package amc_pkg;

    localparam int DIGW = 5;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_ZERO  = 2'd1,
        MS_PLUS1 = 2'd2
    } mod_state_e;

    localparam logic [DIGW-1:0] CODE_ZERO = 5'b11000;

    function automatic logic [3:0] dig_value(input logic [DIGW-1:0] c);
        logic [3:0] v;
        case (c)
            5'b11000: v = 4'd0;
            5'b00011: v = 4'd1;
            5'b00101: v = 4'd2;
            5'b00110: v = 4'd3;
            5'b01001: v = 4'd4;
            5'b01010: v = 4'd5;
            5'b01100: v = 4'd6;
            5'b10001: v = 4'd7;
            5'b10010: v = 4'd8;
            5'b10100: v = 4'd9;
            default:  v = 4'd0;
        endcase
        return v;
    endfunction

    function automatic logic dig_legal(input logic [DIGW-1:0] c);
        int n;
        n = 0;
        for (int b = 0; b < DIGW; b++) begin
            if (c[b]) n++;
        end
        return (n == 2);
    endfunction

    function automatic logic [DIGW-1:0] dig_code(input logic [3:0] v);
        logic [DIGW-1:0] c;
        case (v)
            4'd0:    c = 5'b11000;
            4'd1:    c = 5'b00011;
            4'd2:    c = 5'b00101;
            4'd3:    c = 5'b00110;
            4'd4:    c = 5'b01001;
            4'd5:    c = 5'b01010;
            4'd6:    c = 5'b01100;
            4'd7:    c = 5'b10001;
            4'd8:    c = 5'b10010;
            4'd9:    c = 5'b10100;
            default: c = 5'b11000;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/amc_latch_fsm.sv
module amc_latch_fsm
    import amc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_zero_req,
    input  logic set_plus1_req,
    input  logic latch_reset,
    output logic mod_zero,
    output logic mod_plus1
);

    mod_state_e state_q, state_d;
    logic zero_only;

    assign zero_only = set_zero_req && !set_plus1_req;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: begin
                if (set_plus1_req)  state_d = MS_PLUS1;  // IDLE_TO_PLUS1
                else if (zero_only) state_d = MS_ZERO;   // IDLE_TO_ZERO
            end
            MS_ZERO: begin
                if (latch_reset && !set_zero_req)
                    state_d = set_plus1_req ? MS_PLUS1 : MS_IDLE;  // ZERO_TO_PLUS1 / ZERO_TO_IDLE
            end
            MS_PLUS1: begin
                if (zero_only)                          state_d = MS_ZERO;  // PLUS1_TO_ZERO
                else if (latch_reset && !set_plus1_req) state_d = MS_IDLE;  // PLUS1_TO_IDLE
            end
            default: state_d = MS_IDLE;
        endcase
    end

    always_comb begin
        mod_zero  = (state_q == MS_ZERO);
        mod_plus1 = (state_q == MS_PLUS1);
    end

    AST_PLUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_plus1_req && !mod_zero) |=> (mod_plus1 && !mod_zero)); // R2

    AST_ZERO_RESET_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_zero && set_zero_req) |=> mod_zero); // R3

    AST_ZERO_BLOCKS_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_zero && !(latch_reset && !set_zero_req)) |=> !mod_plus1); // R4

    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_reset && !set_zero_req && !set_plus1_req) |=> (!mod_zero && !mod_plus1)); // R1

endmodule

// File: rtl/amc_digit_inc.sv
module amc_digit_inc
    import amc_pkg::*;
(
    input  logic [DIGW-1:0] code_i,
    input  logic            carry_i,
    output logic [DIGW-1:0] code_o,
    output logic            carry_o,
    output logic            legal_o
);

    logic [3:0] val;

    always_comb begin
        val     = dig_value(code_i);
        legal_o = dig_legal(code_i);
        carry_o = 1'b0;
        code_o  = code_i;
        if (carry_i) begin
            if (val == 4'd9) begin
                code_o  = CODE_ZERO;
                carry_o = 1'b1;
            end else begin
                code_o = dig_code(val + 4'd1);
            end
        end
    end

endmodule

// File: rtl/amc_addr_modifier.sv
module amc_addr_modifier
    import amc_pkg::*;
#(
    parameter int NDIG     = 5,
    parameter int TOP_ADDR = 39999
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_zero_req,
    input  logic                 set_plus1_req,
    input  logic                 latch_reset,
    input  logic                 load_en,
    input  logic [NDIG*5-1:0]    load_addr,
    input  logic                 mod_strobe,
    input  logic                 to_end_mode,
    output logic [NDIG*5-1:0]    addr_out,
    output logic                 mod_zero,
    output logic                 mod_plus1,
    output logic                 digit_check,
    output logic                 addr_check
);

    localparam int AW = NDIG * DIGW;

    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   addr_inc;
    logic [NDIG:0]   carry;
    logic [NDIG-1:0] legal;
    logic            all_legal;
    logic [31:0]     bin_val;
    logic            at_top;
    logic            do_mod;

    amc_latch_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_zero_req  (set_zero_req),
        .set_plus1_req (set_plus1_req),
        .latch_reset   (latch_reset),
        .mod_zero      (mod_zero),
        .mod_plus1     (mod_plus1)
    );

    assign carry[0] = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        amc_digit_inc u_inc (
            .code_i  (addr_q[g*DIGW +: DIGW]),
            .carry_i (carry[g]),
            .code_o  (addr_inc[g*DIGW +: DIGW]),
            .carry_o (carry[g+1]),
            .legal_o (legal[g])
        );
    end

    always_comb begin
        bin_val = 32'd0;
        for (int i = NDIG - 1; i >= 0; i--) begin
            bin_val = bin_val * 32'd10 + {28'd0, dig_value(addr_q[i*DIGW +: DIGW])};
        end
        at_top    = (bin_val >= TOP_ADDR);
        all_legal = &legal;
        do_mod    = mod_strobe && !load_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= {NDIG{CODE_ZERO}};
            digit_check <= 1'b0;
            addr_check  <= 1'b0;
        end else begin
            if (load_en) begin
                addr_q <= load_addr;
            end else if (do_mod && mod_plus1 && all_legal) begin
                addr_q <= at_top ? {NDIG{CODE_ZERO}} : addr_inc;
            end
            if (do_mod && !all_legal)
                digit_check <= 1'b1;
            if (do_mod && mod_plus1 && all_legal && at_top && !to_end_mode)
                addr_check <= 1'b1;
        end
    end

    assign addr_out = addr_q;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (addr_out == $past(load_addr))); // R9

    AST_NO_PLUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_strobe && !load_en && !mod_plus1) |=> $stable(addr_out)); // R4

    AST_ADDR_CHECK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        addr_check |=> addr_check); // R8

    AST_DIGIT_CHECK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        digit_check |=> digit_check); // R8

    AST_END_MODE_NO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_strobe && to_end_mode && !addr_check) |=> !addr_check); // R7

endmodule

// File: tb/amc_addr_modifier_tb.sv
`timescale 1ns/1ps
module amc_addr_modifier_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_zero_req = 1'b0, set_plus1_req = 1'b0, latch_reset = 1'b0;
    logic        load_en = 1'b0, mod_strobe = 1'b0, to_end_mode = 1'b0;
    logic [24:0] load_addr = '0;
    logic [24:0] addr_out;
    logic        mod_zero, mod_plus1, digit_check, addr_check;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    amc_addr_modifier u_dut (
        .clk(clk), .rst_n(rst_n),
        .set_zero_req(set_zero_req), .set_plus1_req(set_plus1_req),
        .latch_reset(latch_reset), .load_en(load_en), .load_addr(load_addr),
        .mod_strobe(mod_strobe), .to_end_mode(to_end_mode),
        .addr_out(addr_out), .mod_zero(mod_zero), .mod_plus1(mod_plus1),
        .digit_check(digit_check), .addr_check(addr_check)
    );

    // digit weights 7,4,2,1,0 (bit 4 .. bit 0)
    function automatic logic [4:0] enc(input int d);
        int w[5] = '{0, 1, 2, 4, 7};
        for (int a = 0; a < 5; a++)
            for (int b = a + 1; b < 5; b++)
                if ((w[a] + w[b]) % 11 == d || (d == 0 && a == 3 && b == 4))
                    if (!(d != 0 && a == 3 && b == 4))
                        return (5'b1 << a) | (5'b1 << b);
        return 5'b00000;
    endfunction

    function automatic logic [24:0] enc_addr(input int v);
        logic [24:0] r;
        int t = v;
        for (int i = 0; i < 5; i++) begin
            r[i*5 +: 5] = enc(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        set_zero_req = 0; set_plus1_req = 0; latch_reset = 0;
        load_en = 0; mod_strobe = 0; to_end_mode = 0;
    endtask

    task automatic do_load(input int v);
        load_en = 1; load_addr = enc_addr(v); tick();
    endtask

    // start, mode (0 none, 1 zero, 2 plus1), end mode, expected address
    localparam int NV = 8;
    localparam int VEC[NV][4] = '{
        '{12345, 2, 0, 12346},
        '{12349, 2, 0, 12350},
        '{19999, 2, 0, 20000},
        '{ 9099, 2, 0,  9100},
        '{39998, 2, 0, 39999},
        '{39999, 2, 1,     0},
        '{27183, 1, 0, 27183},
        '{ 4321, 0, 0,  4321}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mod_zero", mod_zero, 0);
        chk("R1 mod_plus1", mod_plus1, 0);
        chk("R1 checks", {digit_check, addr_check}, 0);
        chk("R1 addr", addr_out, enc_addr(0));
        rst_n = 1; tick();

        // table walk: R5 R7 R9 R10
        for (int k = 0; k < NV; k++) begin
            latch_reset = 1; tick();
            do_load(VEC[k][0]);
            chk("R9 load", addr_out, enc_addr(VEC[k][0]));
            if (VEC[k][1] == 1) set_zero_req = 1;
            if (VEC[k][1] == 2) set_plus1_req = 1;
            tick();
            mod_strobe = 1; to_end_mode = VEC[k][2][0]; tick();
            chk("R5 R7 R10 addr", addr_out, enc_addr(VEC[k][3]));
            chk("R7 no addr_check", addr_check, 0);
        end

        // R2: both requests from idle
        latch_reset = 1; tick();
        set_zero_req = 1; set_plus1_req = 1; tick();
        chk("R2 plus1 wins", {mod_zero, mod_plus1}, 1);
        set_zero_req = 1; tick();
        chk("R2 zero takes over", {mod_zero, mod_plus1}, 2);
        // R3: release blocked while zero request held, stable each cycle
        for (int c = 0; c < 4; c++) begin
            set_zero_req = 1; latch_reset = 1; tick();
            chk("R3 zero held", {mod_zero, mod_plus1}, 2);
        end
        // R4: plus1 blocked, strobe holds
        do_load(500);
        set_plus1_req = 1; tick();
        chk("R4 plus1 blocked", {mod_zero, mod_plus1}, 2);
        set_plus1_req = 1; set_zero_req = 1; latch_reset = 1; tick();
        chk("R4 all three", {mod_zero, mod_plus1}, 2);
        mod_strobe = 1; tick();
        chk("R4 addr held", addr_out, enc_addr(500));
        latch_reset = 1; set_plus1_req = 1; tick();
        chk("R4 release to plus1", {mod_zero, mod_plus1}, 1);
        // R9 load beats strobe
        load_en = 1; load_addr = enc_addr(777); mod_strobe = 1; tick();
        chk("R9 load priority", addr_out, enc_addr(777));
        // R1 release
        latch_reset = 1; tick();
        chk("R1 release idle", {mod_zero, mod_plus1}, 0);

        // R7 top without end mode
        set_plus1_req = 1; tick();
        do_load(39999);
        mod_strobe = 1; tick();
        chk("R7 wrap", addr_out, enc_addr(0));
        chk("R7 addr_check", addr_check, 1);
        // R6 illegal digit (no bits set in digit 2)
        load_en = 1; load_addr = enc_addr(11111) & ~(25'h1f << 10); tick();
        mod_strobe = 1; tick();
        chk("R6 digit_check", digit_check, 1);
        chk("R6 addr held", addr_out, enc_addr(11111) & ~(25'h1f << 10));
        // R8 sticky
        latch_reset = 1; tick();
        do_load(100);
        repeat (3) tick();
        chk("R8 sticky", {digit_check, addr_check}, 3);
        rst_n = 0; tick();
        rst_n = 1; tick();
        chk("R8 cleared by reset", {digit_check, addr_check}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule